// File: doc/BRIEF.md
# Dead-Time Inserter for Half- and Full-Bridge Gate Drive

This block turns PWM commands into high-side and low-side gate-drive lines that are never active at the same time. Each drive line turns off on the clock edge that samples its command low. It turns on only after its command has been held high for a programmed number of clock cycles, and during that whole interval every switch it is interlocked with must be both commanded off and driven off. The high-side and low-side turn-on paths each take their own count, so unequal driver delays can be covered.

Each leg takes a pair of command bits, one for the high switch and one for the low switch. With the full-bridge parameter set, two legs are built. A switch is then also interlocked with the switch at the same position in the other leg. Whenever two interlocked switches are commanded on together, a sticky fault flag is raised. An enable input forces every output low, and the synchronous active-low reset does the same.

Top module: `dead_time_inserter`

## Requirements
- R1: The high and low outputs of the same leg are never high in the same cycle.
- R2: An output drops on the first rising edge that samples its command low. No dead-time count delays a turn-off.
- R3: Let D be the larger of the side's count and 1. A qualifying edge is one at which the side's command is high, enable is high, and every interlocked partner's command and output are low. An output rises on the D-th consecutive qualifying edge. With a count of 0 it rises one edge after the command is first sampled.
- R4: In a direct swap, one side's command falls and the other side's command rises on the same edge. Both outputs of that leg then stay low for exactly D clock cycles, where D comes from the incoming side.
- R5: High-side turn-on uses `dt_hi`. Low-side turn-on uses `dt_lo`.
- R6: A command held high for fewer than D qualifying edges produces no output pulse. A command held for N ≥ D qualifying edges produces an output pulse N−D+1 cycles long.
- R7: If a command falls before its count completes, the pending turn-on is dropped. The next rise of the command starts counting from zero.
- R8: An output does not turn on while an interlocked partner's command or output is high. An output that is already on stays on while its own command stays high.
- R9: In full-bridge mode, the two high outputs are never high together and the two low outputs are never high together. These cross-leg pairs are interlocked in the same way as the two sides of one leg.
- R10: While reset or enable is low, all outputs are low one edge later. A turn-on after enable returns waits out a fresh count.
- R11: `fault` is 0 after reset. It is set one edge after any interlocked pair of commands is sampled high together while reset is high. It then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Output enable; low forces every drive off |
| cmd_hi | input | LEGS | High-switch command per leg (bit 0 = leg 0) |
| cmd_lo | input | LEGS | Low-switch command per leg |
| dt_hi | input | CNT_W | Turn-on count for high-side outputs |
| dt_lo | input | CNT_W | Turn-on count for low-side outputs |
| drv_hi | output | LEGS | High-side gate drive per leg |
| drv_lo | output | LEGS | Low-side gate drive per leg |
| fault | output | 1 | Sticky flag: interlocked commands were high together |

## Verification
The dead-time assertions assume that `dt_hi` and `dt_lo` hold steady while any turn-on count is running. The stimulus therefore changes the counts only on cycles where no command has been high long enough for a count to be under way. All command patterns are applied on the falling clock edge. Conflicting commands are applied only in the closing part of the run, after every non-conflicting pattern has been checked, because the fault flag stays set once it is raised.

// File: rtl/dti_pkg.sv
// Shared helpers for the dead-time inserter.
// Assumes: the full-bridge selector is 0 (one leg) or non-zero (two legs).
package dti_pkg;

    // Number of legs built for the chosen topology.
    function automatic int unsigned leg_count(input int unsigned full_bridge);
        return (full_bridge != 0) ? 2 : 1;
    endfunction

    // Number of interlock partners each switch has: its own leg's
    // opposite side, plus the same position in the other leg if present.
    function automatic int unsigned partner_count(input int unsigned full_bridge);
        return (full_bridge != 0) ? 2 : 1;
    endfunction

endpackage

// File: rtl/dti_channel.sv
// One gate-drive side: a registered output with a turn-on counter.
// Turn-off is immediate. Turn-on waits until the command has been
// qualified (enabled, and no partner requested or driving) for
// max(dead,1) consecutive edges.
// Assumes: dead is stable while a count is running.
module dti_channel #(
    parameter int unsigned CNT_W = 6,
    parameter int unsigned NB    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             req,
    input  logic [NB-1:0]    blk_req,
    input  logic [NB-1:0]    blk_drv,
    input  logic [CNT_W-1:0] dead,
    output logic             drv
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic             blocked;
    logic             qualify;
    logic             ready;
    logic             drv_d;

    // A partner that is commanded on or driving blocks this side.
    assign blocked = (|blk_req) || (|blk_drv);
    // This edge counts toward the turn-on interval.
    assign qualify = en && req && !blocked;
    // This edge completes the interval (a count of 0 acts as 1).
    assign ready   = ({1'b0, cnt} + 1'b1) >= {1'b0, dead};
    // Hold while commanded, or turn on once the interval is complete.
    assign drv_d   = en && req && (drv || (!blocked && ready));

    // Output register and saturating run counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            drv <= 1'b0;
        end else begin
            drv <= drv_d;
            if (!qualify) begin
                cnt <= '0;
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dti_fault.sv
// Sticky conflict detector. Raises the flag one edge after any
// interlocked pair of commands is sampled high together.
// Assumes: cmd bit i belongs to leg i.
module dti_fault #(
    parameter int unsigned LEGS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LEGS-1:0] cmd_hi,
    input  logic [LEGS-1:0] cmd_lo,
    output logic            fault
);

    logic same_leg;
    logic cross_leg;

    // Both switches of any one leg commanded on.
    assign same_leg = |(cmd_hi & cmd_lo);

    if (LEGS > 1) begin : g_cross
        // Both high switches, or both low switches, commanded on.
        assign cross_leg = (&cmd_hi) || (&cmd_lo);
    end else begin : g_single
        assign cross_leg = 1'b0;
    end

    // Latch the flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault <= 1'b0;
        end else if (same_leg || cross_leg) begin
            fault <= 1'b1;
        end
    end

endmodule

// File: rtl/dead_time_inserter.sv
// Top of the dead-time inserter. Builds one or two legs of high and low
// drive channels and wires each channel's interlock partners. In the
// two-leg build each switch also waits on the same position of the
// other leg.
// Assumes: dt_hi and dt_lo change only when no turn-on count is running.
module dead_time_inserter
    import dti_pkg::*;
#(
    parameter  int unsigned FULL_BRIDGE = 1,
    parameter  int unsigned CNT_W       = 6,
    localparam int unsigned LEGS        = leg_count(FULL_BRIDGE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LEGS-1:0]  cmd_hi,
    input  logic [LEGS-1:0]  cmd_lo,
    input  logic [CNT_W-1:0] dt_hi,
    input  logic [CNT_W-1:0] dt_lo,
    output logic [LEGS-1:0]  drv_hi,
    output logic [LEGS-1:0]  drv_lo,
    output logic             fault
);

    localparam int unsigned NB = partner_count(FULL_BRIDGE);

    logic [LEGS-1:0] hi_q;
    logic [LEGS-1:0] lo_q;

    for (genvar i = 0; i < LEGS; i++) begin : g_leg
        logic [NB-1:0] hi_blk_req;
        logic [NB-1:0] hi_blk_drv;
        logic [NB-1:0] lo_blk_req;
        logic [NB-1:0] lo_blk_drv;

        if (LEGS == 2) begin : g_bridge
            localparam int unsigned J = (i == 0) ? 1 : 0;
            // Partners: own leg's opposite side and other leg's same side.
            assign hi_blk_req = {cmd_hi[J], cmd_lo[i]};
            assign hi_blk_drv = {hi_q[J],   lo_q[i]};
            assign lo_blk_req = {cmd_lo[J], cmd_hi[i]};
            assign lo_blk_drv = {lo_q[J],   hi_q[i]};
        end else begin : g_half
            // Partner: own leg's opposite side only.
            assign hi_blk_req = cmd_lo[i];
            assign hi_blk_drv = lo_q[i];
            assign lo_blk_req = cmd_hi[i];
            assign lo_blk_drv = hi_q[i];
        end

        dti_channel #(.CNT_W(CNT_W), .NB(NB)) u_hi (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en),
            .req     (cmd_hi[i]),
            .blk_req (hi_blk_req),
            .blk_drv (hi_blk_drv),
            .dead    (dt_hi),
            .drv     (hi_q[i])
        );

        dti_channel #(.CNT_W(CNT_W), .NB(NB)) u_lo (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en),
            .req     (cmd_lo[i]),
            .blk_req (lo_blk_req),
            .blk_drv (lo_blk_drv),
            .dead    (dt_lo),
            .drv     (lo_q[i])
        );
    end

    dti_fault #(.LEGS(LEGS)) u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_hi (cmd_hi),
        .cmd_lo (cmd_lo),
        .fault  (fault)
    );

    assign drv_hi = hi_q;
    assign drv_lo = lo_q;

endmodule

// File: rtl/dti_checks.sv
// Property checker for the dead-time inserter, bound to the top.
// Assumes: dt_hi and dt_lo are stable while any turn-on count is running.
module dti_checks
    import dti_pkg::*;
#(
    parameter  int unsigned FULL_BRIDGE = 1,
    parameter  int unsigned CNT_W       = 6,
    localparam int unsigned LEGS        = leg_count(FULL_BRIDGE)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [LEGS-1:0]  cmd_hi,
    input logic [LEGS-1:0]  cmd_lo,
    input logic [CNT_W-1:0] dt_hi,
    input logic [CNT_W-1:0] dt_lo,
    input logic [LEGS-1:0]  drv_hi,
    input logic [LEGS-1:0]  drv_lo,
    input logic             fault
);

    logic conflict;

    if (LEGS > 1) begin : g_cc
        assign conflict = (|(cmd_hi & cmd_lo)) || (&cmd_hi) || (&cmd_lo);
    end else begin : g_sc
        assign conflict = |(cmd_hi & cmd_lo);
    end

    for (genvar i = 0; i < LEGS; i++) begin : g_leg
        logic [CNT_W:0] lo_quiet;
        logic [CNT_W:0] hi_quiet;

        // Count cycles each side has been low, saturating.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_quiet <= '0;
                hi_quiet <= '0;
            end else begin
                lo_quiet <= drv_lo[i] ? '0 : ((&lo_quiet) ? lo_quiet : lo_quiet + 1'b1);
                hi_quiet <= drv_hi[i] ? '0 : ((&hi_quiet) ? hi_quiet : hi_quiet + 1'b1);
            end
        end

        assert_leg_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !(drv_hi[i] && drv_lo[i]));

        assert_hi_off_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !cmd_hi[i] |=> !drv_hi[i]);

        assert_lo_off_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !cmd_lo[i] |=> !drv_lo[i]);

        assert_hi_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drv_hi[i]) |-> (lo_quiet != '0) && (lo_quiet >= {1'b0, dt_hi}));

        assert_lo_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drv_lo[i]) |-> (hi_quiet != '0) && (hi_quiet >= {1'b0, dt_lo}));

        assert_disable_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> !drv_hi[i] && !drv_lo[i]);
    end

    if (LEGS > 1) begin : g_bridge
        assert_cross_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(&drv_hi) && !(&drv_lo));
    end

    assert_fault_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> fault);

    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

endmodule

bind dead_time_inserter dti_checks #(
    .FULL_BRIDGE (FULL_BRIDGE),
    .CNT_W       (CNT_W)
) u_checks (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .cmd_hi (cmd_hi),
    .cmd_lo (cmd_lo),
    .dt_hi  (dt_hi),
    .dt_lo  (dt_lo),
    .drv_hi (drv_hi),
    .drv_lo (drv_lo),
    .fault  (fault)
);

// File: tb/tb_dead_time_inserter.sv
// Scoreboard bench: the driver applies commands on the falling edge and
// queues the outputs expected after the next rising edge. The monitor
// pops one item per cycle and compares it.
module tb_dead_time_inserter;

    localparam int CW = 6;

    logic          clk    = 1'b0;
    logic          rst_n  = 1'b0;
    logic          en     = 1'b0;
    logic [1:0]    cmd_hi = '0;
    logic [1:0]    cmd_lo = '0;
    logic [CW-1:0] dt_hi  = '0;
    logic [CW-1:0] dt_lo  = '0;
    logic [1:0]    drv_hi;
    logic [1:0]    drv_lo;
    logic          fault;

    dead_time_inserter #(.FULL_BRIDGE(1), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .dt_hi(dt_hi), .dt_lo(dt_lo), .drv_hi(drv_hi), .drv_lo(drv_lo), .fault(fault)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [3:0] outs;
        logic       flt;
        string      tag;
    } item_t;

    item_t sbq[$];
    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // Settings applied at the next falling edge.
    logic          w_rst  = 1'b0;
    logic          w_en   = 1'b0;
    logic [CW-1:0] w_dthi = '0;
    logic [CW-1:0] w_dtlo = '0;

    // Expected state. Index 0 = hi0, 1 = lo0, 2 = hi1, 3 = lo1.
    logic [3:0] m_out = '0;
    logic       m_flt = 1'b0;
    int         m_run [4] = '{0, 0, 0, 0};

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Expected outputs after the coming edge, from the requirements.
    task automatic model_step(input string tag);
        logic [3:0] c;
        logic [3:0] nxt;
        int         nrun [4];
        item_t      it;
        c = {cmd_lo[1], cmd_hi[1], cmd_lo[0], cmd_hi[0]};
        if (!rst_n) begin
            nxt   = '0;
            m_flt = 1'b0;
            for (int o = 0; o < 4; o++) nrun[o] = 0;
        end else begin
            for (int o = 0; o < 4; o++) begin
                bit blocked;
                int d;
                blocked = c[o ^ 1] || c[o ^ 2] || m_out[o ^ 1] || m_out[o ^ 2];
                d = (o % 2 == 0) ? int'(dt_hi) : int'(dt_lo);
                if (d < 1) d = 1;
                nrun[o] = (en && c[o] && !blocked) ? m_run[o] + 1 : 0;
                nxt[o]  = en && c[o] && (m_out[o] || (!blocked && nrun[o] >= d));
            end
            if ((c[0] && c[1]) || (c[2] && c[3]) || (c[0] && c[2]) || (c[1] && c[3]))
                m_flt = 1'b1;
        end
        for (int o = 0; o < 4; o++) m_run[o] = nrun[o];
        m_out   = nxt;
        it.outs = nxt;
        it.flt  = m_flt;
        it.tag  = tag;
        sbq.push_back(it);
    endtask

    // Driver: hold the given commands for n cycles.
    task automatic cyc(input logic [1:0] h, input logic [1:0] l, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rst_n  = w_rst;
            en     = w_en;
            dt_hi  = w_dthi;
            dt_lo  = w_dtlo;
            cmd_hi = h;
            cmd_lo = l;
            model_step(tag);
        end
    endtask

    // Monitor: compare one queued item per cycle, away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                item_t it;
                logic [3:0] act;
                it  = sbq.pop_front();
                act = {drv_lo[1], drv_hi[1], drv_lo[0], drv_hi[0]};
                chk(act === it.outs, it.tag, "drive", int'(act), int'(it.outs));
                chk(fault === it.flt, it.tag, "fault", int'(fault), int'(it.flt));
                chk(!(drv_hi[0] && drv_lo[0]) && !(drv_hi[1] && drv_lo[1]), "R1",
                    "leg overlap", int'(act), 0);
                chk(!(&drv_hi) && !(&drv_lo), "R9", "cross overlap", int'(act), 0);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R10: reset holds all outputs low; a conflict during reset raises no fault.
        w_rst = 0; w_en = 1; w_dthi = 3; w_dtlo = 5;
        cyc(2'b11, 2'b11, 4, "R10");
        w_rst = 1;
        cyc(2'b00, 2'b00, 3, "R10");

        // R3: diagonal turn-on from idle (hi0 and lo1).
        cyc(2'b01, 2'b10, 8, "R3");
        // R4: direct swap to the other diagonal.
        cyc(2'b10, 2'b01, 10, "R4");
        // R5: swap back; high and low sides use different counts.
        cyc(2'b01, 2'b10, 8, "R5");
        // R2: all commands drop; outputs fall at once.
        cyc(2'b00, 2'b00, 3, "R2");

        // R6: pulses shorter than, equal to and longer than the count.
        w_dthi = 4;
        cyc(2'b00, 2'b00, 1, "R6");
        cyc(2'b01, 2'b00, 3, "R6");
        cyc(2'b00, 2'b00, 3, "R6");
        cyc(2'b01, 2'b00, 4, "R6");
        cyc(2'b00, 2'b00, 3, "R6");
        cyc(2'b01, 2'b00, 6, "R6");
        cyc(2'b00, 2'b00, 3, "R6");

        // R7: command drops mid-count, then the count restarts.
        cyc(2'b01, 2'b00, 3, "R7");
        cyc(2'b00, 2'b00, 1, "R7");
        cyc(2'b01, 2'b00, 5, "R7");
        cyc(2'b00, 2'b00, 3, "R7");

        // R3 boundaries: counts of 0, 1 and the maximum.
        w_dthi = 0;
        cyc(2'b00, 2'b00, 1, "R3");
        cyc(2'b01, 2'b00, 3, "R3");
        cyc(2'b00, 2'b00, 2, "R3");
        w_dthi = 1;
        cyc(2'b00, 2'b00, 1, "R3");
        cyc(2'b01, 2'b00, 3, "R3");
        cyc(2'b00, 2'b00, 2, "R3");
        w_dthi = 63;
        cyc(2'b00, 2'b00, 1, "R3");
        cyc(2'b01, 2'b00, 66, "R3");
        cyc(2'b00, 2'b00, 2, "R3");

        // R4: a swap with a low-side count of 0 still leaves one idle cycle.
        w_dthi = 2; w_dtlo = 0;
        cyc(2'b00, 2'b00, 1, "R4");
        cyc(2'b01, 2'b00, 4, "R4");
        cyc(2'b00, 2'b01, 4, "R4");
        cyc(2'b00, 2'b00, 2, "R4");

        // R10: enable low mid-pulse forces the outputs low; a fresh count follows.
        w_dtlo = 5;
        cyc(2'b01, 2'b00, 5, "R10");
        w_en = 0;
        cyc(2'b01, 2'b00, 3, "R10");
        w_en = 1;
        cyc(2'b01, 2'b00, 6, "R10");
        cyc(2'b00, 2'b00, 2, "R10");

        // R8 and R11: same-leg conflict from idle blocks both sides and raises the fault.
        cyc(2'b01, 2'b01, 5, "R11");
        cyc(2'b01, 2'b00, 4, "R8");
        cyc(2'b01, 2'b01, 4, "R8");
        cyc(2'b00, 2'b01, 8, "R8");
        cyc(2'b00, 2'b00, 2, "R8");

        // R9: cross-leg high request waits for the other high side to release.
        cyc(2'b01, 2'b00, 6, "R9");
        cyc(2'b11, 2'b00, 6, "R9");
        cyc(2'b10, 2'b00, 6, "R9");
        cyc(2'b00, 2'b00, 2, "R9");

        // R11: only reset clears the fault.
        w_rst = 0;
        cyc(2'b00, 2'b00, 2, "R11");
        w_rst = 1;
        cyc(2'b00, 2'b00, 3, "R11");

        @(posedge clk);
        #3;
        finish_run();
    end

endmodule